// File: doc/BRIEF.md
# Decimation Chain Rate Sequencer

This block produces all of the timing strobes for a three-stage cascaded decimating filter that sits behind an oversampling modulator. It runs from the master clock and derives a modulator-sample enable at half that rate. From it the block derives one sample enable per filter stage: a fixed divide-by-4 first stage, a middle stage that divides by 8, 16 or 32, and a fixed divide-by-2 last stage. The overall decimation is therefore 64, 128 or 256 modulator samples per output word.

A restart pulse aligns every stage phase to a common origin and loads the decimation select. It also restarts a settle timer. The timer raises a "settled" flag once the filter's impulse response has filled, after a per-mode number of master clocks. The output-data-ready strobe is the last-stage enable gated by that flag. No word is offered before the filter has settled.

Top module: `decim_rate_seq`

## Requirements
- R1: `mod_en` is high on every second master clock. It is low in the first cycle after a reset or restart edge and high in the second.
- R2: `s1_en` is high on every fourth `mod_en` pulse, and only together with it. In the 8 master clocks after a restart edge it is high in the eighth only.
- R3: `s2_en` is high on every Mth `s1_en` pulse, and only together with it. M is 8, 16 or 32 for a latched select of 2'b00, 2'b01 or 2'b10. The code 2'b11 behaves as 2'b10.
- R4: `s3_en` is high on every second `s2_en` pulse, and only together with it. This gives an output period of 128, 256 or 512 master clocks for the three selects.
- R5: `settled` goes high exactly N master clocks after the restart or reset edge. N is 7122 for select 2'b00, 14217 for 2'b01 and 27895 for 2'b10 or 2'b11.
- R6: A `sync_i` high at a clock edge clears all stage phases and the settle timer, and drives `settled` low in the next cycle.
- R7: `ratio_sel` is sampled only at an edge with `sync_i` high. A change at any other time has no effect on the strobes or on the settle time. Reset selects the 2'b00 mode.
- R8: `drdy` is high exactly when `s3_en` and `settled` are both high. Each pulse is one master clock wide.
- R9: Once high, `settled` stays high until the next restart or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Restart pulse, active high, synchronous |
| ratio_sel | input | 2 | Overall decimation select, latched on restart |
| mod_en | output | 1 | Modulator-sample enable (half master rate) |
| s1_en | output | 1 | First-stage output enable |
| s2_en | output | 1 | Middle-stage output enable |
| s3_en | output | 1 | Last-stage output enable |
| drdy | output | 1 | Output-data-ready strobe, qualified by settle |
| settled | output | 1 | Filter-settled status flag |

## Verification
The assertions check on every cycle the properties that do not depend on the mode. These are the alternation of the modulator enable, the nesting of each stage enable inside the one before it, the gating of the ready strobe, the clearing of the flag after a restart, the holding of the flag once set, and the holding of the latched select between restarts. Only the bench's scenarios can show the exact stage periods for each select and the exact settle count in each of the three modes. They also show that a select change without a restart leaves the timing alone, and that a restart in the middle of an output period realigns every phase. A reference model counts master clocks since the last restart and predicts every output on every cycle.

// File: rtl/decim_rate_pkg.sv
package decim_rate_pkg;

   typedef enum logic [1:0] {
      RATIO_64  = 2'b00,
      RATIO_128 = 2'b01,
      RATIO_256 = 2'b10,
      RATIO_RSV = 2'b11
   } ratio_e;

   localparam int unsigned NUM_STAGES = 4;   // modulator divider + three filter stages

endpackage

// File: rtl/dr_phase_div.sv
module dr_phase_div #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] last,
   output logic             tick
);

   logic [CNT_W-1:0] phase_q;

   assign tick = en && (phase_q == last);

   always_ff @(posedge clk) begin
      if (clr)
         phase_q <= '0;
      else if (en)
         phase_q <= (phase_q == last) ? '0 : phase_q + 1'b1;
   end

endmodule

// File: rtl/dr_settle_timer.sv
module dr_settle_timer #(
   parameter int unsigned SW = 15
) (
   input  logic          clk,
   input  logic          clr,
   input  logic [SW-1:0] limit,
   output logic          done
);

   logic [SW-1:0] count_q;
   logic          done_q;

   assign done = done_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         count_q <= '0;
         done_q  <= 1'b0;
      end else if (!done_q) begin
         count_q <= count_q + 1'b1;
         if (count_q == limit - 1'b1)
            done_q <= 1'b1;
      end
   end

endmodule

// File: rtl/decim_rate_seq.sv
module decim_rate_seq #(
   parameter int unsigned MOD_DIV     = 2,
   parameter int unsigned S1_DIV      = 4,
   parameter int unsigned MID_DIV_LO  = 8,
   parameter int unsigned S3_DIV      = 2,
   parameter int unsigned SETTLE_LO   = 7122,
   parameter int unsigned SETTLE_MID  = 14217,
   parameter int unsigned SETTLE_HI   = 27895,
   parameter bit          RSV_IS_HI   = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       sync_i,
   input  logic [1:0] ratio_sel,
   output logic       mod_en,
   output logic       s1_en,
   output logic       s2_en,
   output logic       s3_en,
   output logic       drdy,
   output logic       settled
);
   import decim_rate_pkg::*;

   localparam int unsigned MID_DIV_HI = MID_DIV_LO * 4;
   localparam int unsigned CNT_W      = $clog2(MID_DIV_HI);
   localparam int unsigned SW         = $clog2(SETTLE_HI + 1);

   if (MOD_DIV < 2 || S1_DIV < 2 || S3_DIV < 2 || MID_DIV_LO < 2) begin : g_bad_div
      $error("decim_rate_seq: every divide ratio must be at least 2");
   end
   if (MOD_DIV > MID_DIV_HI || S1_DIV > MID_DIV_HI || S3_DIV > MID_DIV_HI) begin : g_bad_width
      $error("decim_rate_seq: fixed divide ratio exceeds phase counter range");
   end
   if (SETTLE_LO < 2 || SETTLE_MID < SETTLE_LO || SETTLE_HI < SETTLE_MID) begin : g_bad_settle
      $error("decim_rate_seq: settle counts must be at least 2 and non-decreasing");
   end

   logic       clr;
   ratio_e     mode_q;
   ratio_e     mode_eff;

   assign clr = rst | sync_i;

   always_ff @(posedge clk) begin
      if (rst)
         mode_q <= RATIO_64;
      else if (sync_i)
         mode_q <= ratio_e'(ratio_sel);
   end

   if (RSV_IS_HI) begin : g_rsv_hi
      assign mode_eff = (mode_q == RATIO_RSV) ? RATIO_256 : mode_q;
   end else begin : g_rsv_lo
      assign mode_eff = (mode_q == RATIO_RSV) ? RATIO_64 : mode_q;
   end

   logic [CNT_W-1:0] mid_last;
   logic [SW-1:0]    settle_lim;

   always_comb begin
      unique case (mode_eff)
         RATIO_128: begin
            mid_last   = CNT_W'(MID_DIV_LO * 2 - 1);
            settle_lim = SW'(SETTLE_MID);
         end
         RATIO_256, RATIO_RSV: begin
            mid_last   = CNT_W'(MID_DIV_HI - 1);
            settle_lim = SW'(SETTLE_HI);
         end
         default: begin
            mid_last   = CNT_W'(MID_DIV_LO - 1);
            settle_lim = SW'(SETTLE_LO);
         end
      endcase
   end

   logic [CNT_W-1:0]      last_v [NUM_STAGES];
   logic [NUM_STAGES:0]   en_chain;

   assign last_v[0] = CNT_W'(MOD_DIV - 1);
   assign last_v[1] = CNT_W'(S1_DIV - 1);
   assign last_v[2] = mid_last;
   assign last_v[3] = CNT_W'(S3_DIV - 1);
   assign en_chain[0] = 1'b1;

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      dr_phase_div #(.CNT_W(CNT_W)) u_div (
         .clk  (clk),
         .clr  (clr),
         .en   (en_chain[i]),
         .last (last_v[i]),
         .tick (en_chain[i+1])
      );
   end

   dr_settle_timer #(.SW(SW)) u_settle (
      .clk   (clk),
      .clr   (clr),
      .limit (settle_lim),
      .done  (settled)
   );

   assign mod_en = en_chain[1];
   assign s1_en  = en_chain[2];
   assign s2_en  = en_chain[3];
   assign s3_en  = en_chain[4];
   assign drdy   = en_chain[4] & settled;

endmodule

// File: rtl/decim_rate_seq_chk.sv
module decim_rate_seq_chk (
   input logic       clk,
   input logic       rst,
   input logic       sync_i,
   input logic [1:0] mode_q,
   input logic       mod_en,
   input logic       s1_en,
   input logic       s2_en,
   input logic       s3_en,
   input logic       drdy,
   input logic       settled
);

   // R1
   mod_alt_hi_chk: assert property (@(posedge clk) disable iff (rst)
      mod_en |=> !mod_en);
   // R1
   mod_alt_lo_chk: assert property (@(posedge clk) disable iff (rst)
      (!mod_en && !sync_i) |=> mod_en);
   // R2
   s1_nest_chk: assert property (@(posedge clk) disable iff (rst)
      s1_en |-> mod_en);
   // R3
   s2_nest_chk: assert property (@(posedge clk) disable iff (rst)
      s2_en |-> s1_en);
   // R4
   s3_nest_chk: assert property (@(posedge clk) disable iff (rst)
      s3_en |-> s2_en);
   // R8
   drdy_gate_chk: assert property (@(posedge clk) disable iff (rst)
      drdy |-> (s3_en && settled));
   // R8
   drdy_width_chk: assert property (@(posedge clk) disable iff (rst)
      drdy |=> !drdy);
   // R6
   sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
      sync_i |=> (!settled && !mod_en));
   // R9
   settled_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (settled && !sync_i) |=> settled);
   // R7
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !sync_i |=> $stable(mode_q));

endmodule

bind decim_rate_seq decim_rate_seq_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .sync_i  (sync_i),
   .mode_q  (mode_q),
   .mod_en  (mod_en),
   .s1_en   (s1_en),
   .s2_en   (s2_en),
   .s3_en   (s3_en),
   .drdy    (drdy),
   .settled (settled)
);

// File: tb/decim_rate_seq_test.sv
`timescale 1ns/1ps
module decim_rate_seq_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sync_i = 1'b0;
   logic [1:0] ratio_sel = 2'b00;
   logic       mod_en, s1_en, s2_en, s3_en, drdy, settled;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit check_on = 1'b0;

   // reference model state: master clocks since last restart, latched mode
   int k = 0;
   int mode = 0;

   always #2.5 clk = ~clk;

   decim_rate_seq uut (
      .clk(clk), .rst(rst), .sync_i(sync_i), .ratio_sel(ratio_sel),
      .mod_en(mod_en), .s1_en(s1_en), .s2_en(s2_en), .s3_en(s3_en),
      .drdy(drdy), .settled(settled)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst) begin
         k <= 0;
         mode <= 0;
      end else if (sync_i) begin
         k <= 0;
         mode <= (ratio_sel == 2'b11) ? 2 : int'(ratio_sel);
      end else begin
         k <= k + 1;
      end
   end

   task automatic cmp(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b (k=%0d mode=%0d)", tag, got, exp, k, mode);
      end
   endtask

   always @(negedge clk) begin
      if (check_on) begin
         int m2, p2, p3, n;
         logic e_mod, e_s1, e_s2, e_s3, e_set;
         m2 = 8 << mode;
         p2 = 8 * m2;
         p3 = 16 * m2;
         n  = (mode == 0) ? 7122 : (mode == 1) ? 14217 : 27895;
         e_mod = (k % 2) == 1;
         e_s1  = (k % 8) == 7;
         e_s2  = (k % p2) == p2 - 1;
         e_s3  = (k % p3) == p3 - 1;
         e_set = k >= n;
         cmp("R1 mod_en", mod_en, e_mod);
         cmp("R2 s1_en", s1_en, e_s1);
         cmp("R3 s2_en", s2_en, e_s2);
         cmp("R4 s3_en", s3_en, e_s3);
         cmp("R5/R9 settled", settled, e_set);
         cmp("R8 drdy", drdy, e_s3 && e_set);
      end
   end

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cycles > 190000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
         finish_run();
      end
   end

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic restart(input logic [1:0] sel);
      @(posedge clk); #1;
      sync_i = 1'b1;
      ratio_sel = sel;
      @(posedge clk); #1;
      sync_i = 1'b0;
   endtask

   initial begin
      // reset state (R7: reset selects x64 timing)
      @(posedge clk); #1;
      check_on = 1'b1;
      run(3);
      rst = 1'b0;
      // x64 through settle and several outputs (R1..R5, R8)
      run(7600);
      // R7: select change without restart has no effect
      ratio_sel = 2'b10;
      run(1500);
      // R6: restart in the middle of an output period, x128
      run(37);
      restart(2'b01);
      ratio_sel = 2'b00;
      run(15000);
      // x256 mode
      restart(2'b10);
      run(29000);
      // R3/R5: code 11 acts as x256; restart again before settle (R6)
      restart(2'b11);
      run(3000);
      restart(2'b00);
      run(7300);
      // R9 hold, then reset mid-run returns to x64 timing (R7)
      ratio_sel = 2'b01;
      restart(2'b01);
      run(500);
      @(posedge clk); #1;
      rst = 1'b1;
      run(2);
      rst = 1'b0;
      run(7300);
      finish_run();
   end

endmodule